// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital control side of an 8-bit successive-approximation converter. A conversion starts in one of two ways. The first is a software start pulse. The second is a falling edge on an external trigger pin, which is synchronized into the clock domain first. A select input chooses which of the two is live.

Once a conversion runs, the block drives a trial code to an external DAC and comparator and reads back one comparator bit per step. It settles the code from the top bit down. The final code goes into a result register, and a one-cycle completion strobe marks the moment the new value is there. Steps are paced by a conversion clock at half the system clock rate. Idle lead-in cycles make a conversion take exactly 50 system clocks in fast timing and exactly 56 in slow timing.

Any new start during a conversion throws away the work so far and begins again from the top bit. The result register keeps its old value until a conversion runs all the way to the end.

A sticky interrupt flag collects events until software clears it. The events are completion or trigger-pin edges, chosen by a source select bit. A change of that select bit also sets the flag. The comparator bit and the trial code form an analog loop that is sampled on fixed cycles, so they are plain signals with no valid/ready handshake. The result is qualified by the completion strobe.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `irq_flag` are 0, `result` is 0, and `trial_code` is 0. While no conversion is running, `trial_code` stays 0.
- R2: The first trial code of every conversion is 8'b1000_0000. At each decision, the bit under test is kept when `cmp_in` is 1 and cleared when it is 0, and the next lower bit is set. The analog side treats a trial code t as the threshold (2t-1) half-LSBs.
- R3: At completion, `result` holds the 8-bit code settled by the eight decisions. For an input of v half-LSBs this is min(255, (v+1)/2).
- R4: Let the rising edge that accepts a start be edge 0. `done` is first seen high after edge 50 when `slow_mode` is 0, and after edge 56 when it is 1. `slow_mode` is sampled when the start is accepted. Decisions fall every 4 system clocks, i.e. every 2 conversion clocks. The last decision is at the completion edge, and the first is 4 edges after the lead-in.
- R5: `result` changes only in the cycle where `done` is high. At all other times it keeps the previous conversion's value, including during aborted conversions.
- R6: With `trig_sel` = 0, `sw_start` starts a conversion and `trig_pin` has no effect on conversions. With `trig_sel` = 1, a falling edge on `trig_pin` is accepted on the third rising edge after the pin falls (two-flop synchronizer plus edge detect), and `sw_start` has no effect.
- R7: A start accepted while `busy` is 1 restarts the conversion from the first trial code. The full duration of R4 counts from the new start, and no `done` is given for the aborted run.
- R8: `busy` is 1 from the cycle after the accepting edge until completion. `done` is a single-cycle pulse, and `busy` is 0 in the cycle `done` is high.
- R9: `irq_flag` is set one cycle after `done` when `irq_sel` = 0, or by a synchronized falling edge on `trig_pin` when `irq_sel` = 1 (whatever `trig_sel` is). It stays set until `irq_clr`, and a set in the same cycle as a clear wins.
- R10: Any change of `irq_sel` relative to its last sampled value (0 after reset) sets `irq_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mode | input | 1 | 0: 50-clock conversion, 1: 56-clock conversion |
| trig_sel | input | 1 | Start source: 0 software, 1 trigger pin |
| sw_start | input | 1 | Software start pulse |
| trig_pin | input | 1 | External trigger, falling-edge active, asynchronous |
| irq_sel | input | 1 | Interrupt source: 0 completion, 1 trigger-pin edge |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial threshold |
| trial_code | output | 8 | Trial code to the DAC, 0 when idle |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 8 | Last completed conversion code |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The hardest case to reach from the ports is an abort. A trigger-pin falling edge has to land in the middle of a running conversion, after the pin has been high long enough for the synchronizer to see a fresh edge. The bench also has to show that neither the result nor the completion strobe reacts to the abandoned run. The stimulus changes the pin only on falling clock edges, counts rising edges from each pin change, and releases the pin for several cycles before the second fall. This makes the restart edge and the new completion cycle predictable down to one clock. A comparator model inside the bench closes the analog loop, using the half-LSB-shifted threshold, so that every decision depends on the trial code the block presents.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic {
    SRC_SW  = 1'b0,
    SRC_PIN = 1'b1
  } start_src_e;

  typedef enum logic {
    IRQ_ON_DONE = 1'b0,
    IRQ_ON_PIN  = 1'b1
  } irq_src_e;
endpackage

// File: rtl/sar_trig_sync.sv
module sar_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              pin_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= pin_async;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], pin_async};
    end
  endgenerate

  assign pin_s = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;

  assign fall = prev_q & ~pin_s;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R6
endmodule

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
  parameter int unsigned RES        = 8,
  parameter int unsigned STEP_CLKS  = 4,
  parameter int unsigned FAST_TOTAL = 50,
  parameter int unsigned SLOW_TOTAL = 56
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_mode,
  input  logic start,
  output logic busy,
  output logic decide,
  output logic last,
  output logic done
);
  localparam int unsigned CW        = $clog2(SLOW_TOTAL + 1);
  localparam int unsigned SW        = $clog2(STEP_CLKS);
  localparam int unsigned CONV_CLKS = RES * STEP_CLKS;

  logic [CW-1:0] cnt, total, pre;
  logic [SW-1:0] ph;
  logic          mode_q;
  logic          in_conv;

  assign total   = mode_q ? CW'(SLOW_TOTAL) : CW'(FAST_TOTAL);
  assign pre     = total - CW'(CONV_CLKS);
  assign in_conv = busy && (cnt >= pre);
  assign decide  = in_conv && (ph == SW'(STEP_CLKS - 1)) && !start;
  assign last    = decide && (cnt == total - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      ph     <= '0;
      mode_q <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      ph     <= '0;
      mode_q <= slow_mode;
      done   <= 1'b0;
    end else if (busy) begin
      if (cnt == total - 1'b1) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        done <= 1'b0;
      end
      if (in_conv) ph <= ph + 1'b1;
    end else begin
      done <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < total)); // R4
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int unsigned RES = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           decide,
  input  logic           last,
  input  logic           busy,
  input  logic           cmp_in,
  output logic [RES-1:0] trial_code,
  output logic [RES-1:0] result
);
  localparam logic [RES-1:0] TOP = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] sar_q, mask_q, kept;

  assign kept       = cmp_in ? sar_q : (sar_q & ~mask_q);
  assign trial_code = busy ? sar_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q  <= '0;
      mask_q <= '0;
      result <= '0;
    end else if (start) begin
      sar_q  <= TOP;
      mask_q <= TOP;
    end else if (decide) begin
      sar_q  <= last ? kept : (kept | (mask_q >> 1));
      mask_q <= mask_q >> 1;
      if (last) result <= kept;
    end
  end

  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (trial_code == TOP)); // R2
  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot0(mask_q)); // R2
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned RES        = 8,
  parameter int unsigned STEP_CLKS  = 4,
  parameter int unsigned FAST_TOTAL = 50,
  parameter int unsigned SLOW_TOTAL = 56,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slow_mode,
  input  logic           trig_sel,
  input  logic           sw_start,
  input  logic           trig_pin,
  input  logic           irq_sel,
  input  logic           irq_clr,
  input  logic           cmp_in,
  output logic [RES-1:0] trial_code,
  output logic           busy,
  output logic           done,
  output logic [RES-1:0] result,
  output logic           irq_flag
);
  import sar_adc_pkg::*;

  start_src_e src;
  irq_src_e   isrc;
  logic       pin_fall, start_req, decide, last;
  logic       sel_q, sel_chg, irq_evt;

  assign src  = start_src_e'(trig_sel);
  assign isrc = irq_src_e'(irq_sel);

  sar_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(trig_pin), .fall(pin_fall)
  );

  assign start_req = (src == SRC_PIN) ? pin_fall : sw_start;

  sar_step_timer #(
    .RES(RES), .STEP_CLKS(STEP_CLKS),
    .FAST_TOTAL(FAST_TOTAL), .SLOW_TOTAL(SLOW_TOTAL)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .start(start_req),
    .busy(busy), .decide(decide), .last(last), .done(done)
  );

  sar_code_reg #(.RES(RES)) u_code (
    .clk(clk), .rst_n(rst_n), .start(start_req), .decide(decide),
    .last(last), .busy(busy), .cmp_in(cmp_in),
    .trial_code(trial_code), .result(result)
  );

  assign sel_chg = irq_sel != sel_q;
  assign irq_evt = ((isrc == IRQ_ON_PIN) ? pin_fall : done) | sel_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      sel_q    <= irq_sel;
      irq_flag <= (irq_flag & ~irq_clr) | irq_evt;
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag); // R9
  AST_SEL_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> irq_flag); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
endmodule

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
  localparam int FAST = 50;
  localparam int SLOW = 56;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_mode = 1'b0, trig_sel = 1'b0, sw_start = 1'b0;
  logic       trig_pin = 1'b1, irq_sel = 1'b0, irq_clr = 1'b0;
  logic       cmp_in;
  logic [7:0] trial_code, result;
  logic       busy, done, irq_flag;
  logic [8:0] vin_half = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  // analog model: threshold of trial t is (2t-1) half-LSBs
  assign cmp_in = (int'(vin_half) >= 2 * int'(trial_code) - 1);

  sar_adc_ctrl u_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .trig_sel(trig_sel),
    .sw_start(sw_start), .trig_pin(trig_pin), .irq_sel(irq_sel),
    .irq_clr(irq_clr), .cmp_in(cmp_in), .trial_code(trial_code),
    .busy(busy), .done(done), .result(result), .irq_flag(irq_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  function automatic int exp_code(input int v);
    int c = (v + 1) / 2;
    if (c > 255) c = 255;
    return c;
  endfunction

  task automatic sw_pulse();
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
  endtask

  task automatic clr_irq();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  // counts negedges until done; checks result hold on the way
  task automatic wait_done(input int hold, output int k);
    k = 0;
    while (!done && k < 200) begin
      if (int'(result) != hold) begin
        chk("R5", "result held during conversion", int'(result), hold);
      end
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "irq_flag", int'(irq_flag), 0);
    chk("R1", "result", int'(result), 0);
    chk("R1", "idle trial_code", int'(trial_code), 0);
  endtask

  task automatic t_sw_conv(input int v, input logic slow);
    int total = slow ? SLOW : FAST;
    int pre = total - 32;
    int hold;
    int k = 0;
    vin_half = 9'(v);
    slow_mode = slow;
    trig_sel = 1'b0;
    hold = int'(result);
    sw_pulse();
    chk("R8", "busy after start", int'(busy), 1);
    chk("R2", "first trial", int'(trial_code), 128);
    while (!done && k < 200) begin
      if (k == pre + 4)
        chk("R2", "second trial", int'(trial_code), (v >= 255) ? 192 : 64);
      if (int'(result) != hold) chk("R5", "result held", int'(result), hold);
      @(negedge clk);
      k++;
    end
    chk("R4", slow ? "slow duration" : "fast duration", k, total);
    chk("R3", "result code", int'(result), exp_code(v));
    chk("R8", "busy low at done", int'(busy), 0);
    @(negedge clk);
    chk("R8", "done single cycle", int'(done), 0);
    chk("R1", "trial 0 when idle", int'(trial_code), 0);
  endtask

  task automatic t_pin_restart();
    int k;
    int hold = int'(result);
    trig_sel = 1'b1;
    slow_mode = 1'b0;
    vin_half = 9'd300;
    @(negedge clk) trig_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6", "busy before sync latency", int'(busy), 0);
    @(negedge clk);
    chk("R6", "busy on third edge", int'(busy), 1);
    repeat (12) @(negedge clk);
    trig_pin = 1'b1;
    repeat (5) @(negedge clk);
    trig_pin = 1'b0;
    wait_done(hold, k);
    chk("R7", "pin restart duration", k, 3 + FAST);
    chk("R3", "code after restart", int'(result), exp_code(300));
    @(negedge clk) trig_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_sw_restart();
    int k;
    int hold = int'(result);
    trig_sel = 1'b0;
    slow_mode = 1'b1;
    vin_half = 9'd77;
    sw_pulse();
    repeat (30) @(negedge clk);
    chk("R7", "still busy before restart", int'(busy), 1);
    sw_pulse();
    chk("R7", "trial back to top", int'(trial_code), 128);
    wait_done(hold, k);
    chk("R7", "sw restart duration", k, SLOW);
    chk("R3", "code after sw restart", int'(result), exp_code(77));
    @(negedge clk);
  endtask

  task automatic t_ignore();
    trig_sel = 1'b1;
    sw_pulse();
    repeat (4) @(negedge clk);
    chk("R6", "sw_start ignored in pin mode", int'(busy), 0);
    trig_sel = 1'b0;
    @(negedge clk) trig_pin = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6", "pin ignored in sw mode", int'(busy), 0);
    trig_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_irq();
    clr_irq();
    chk("R9", "flag cleared", int'(irq_flag), 0);
    t_sw_conv(20, 1'b0);
    chk("R9", "flag after done", int'(irq_flag), 1);
    clr_irq();
    chk("R9", "flag cleared again", int'(irq_flag), 0);
    @(negedge clk) irq_sel = 1'b1;
    @(negedge clk);
    chk("R10", "select change sets flag", int'(irq_flag), 1);
    clr_irq();
    t_sw_conv(400, 1'b0);
    @(negedge clk);
    chk("R9", "done not a source in pin mode", int'(irq_flag), 0);
    @(negedge clk) trig_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "pin edge sets flag", int'(irq_flag), 1);
    chk("R6", "no conversion from pin in sw mode", int'(busy), 0);
    trig_pin = 1'b1;
    clr_irq();
    @(negedge clk) irq_sel = 1'b0;
    @(negedge clk);
    chk("R10", "select change back sets flag", int'(irq_flag), 1);
    clr_irq();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sw_conv(0, 1'b0);
    t_sw_conv(1, 1'b0);
    t_sw_conv(511, 1'b0);
    t_sw_conv(510, 1'b1);
    t_sw_conv(300, 1'b1);
    t_sw_conv(2, 1'b0);
    t_pin_restart();
    t_sw_restart();
    t_ignore();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule